// File: doc/BRIEF.md
# Application Service Watchdog with Silent Lockout

The block checks that host software keeps reading the upper byte of a watchdog register within a programmable window. The window is set by an 8-bit limit. One limit unit is 256 ticks of the nominal time base, so the window is the limit times 256 ticks. Each read strobe of the upper byte restarts the window. If the window runs out first, a sticky fault flag is set. While that flag is set, the block asks the controller to stop all time-triggered traffic and to enter silent mode.

Recovery is only possible in configuration mode: software writes a zero to the flag. Counting is frozen while configuration mode is active, so every exit from configuration mode starts a fresh window. The watchdog is switched off only when both conditions hold: the test disable bit is set and the limit is zero.

Top module: `app_wdog`

## Requirements
- R1: With the watchdog running, the fault flag becomes 1 on the tick that completes limit×256 counted ticks since the last service. It is still 0 after one tick fewer.
- R2: A service read strobe restarts the window from zero. A tick that arrives in the same cycle as a service read is not counted.
- R3: A limit of 0 with the disable bit at 0 is a zero-length window. The first tick after service sets the fault.
- R4: Once set, the fault flag stays 1 through further ticks and service reads.
- R5: `halt_tt_o` and `silent_o` are 1 exactly while the fault flag is 1.
- R6: A flag write with data bit 15 at 0 clears the fault, but only while `cfg_mode_i` is 1.
- R7: A flag write while `cfg_mode_i` is 0 leaves the fault unchanged. So does a write with bit 15 at 1, in any mode.
- R8: With `test_dis_i`=1 and `limit_i`=0 no fault is ever set. If only one of the two conditions holds, the watchdog keeps running.
- R9: A low on `rst_ni` clears the fault flag, the tick prescaler and the window counter.
- R10: Ticks are ignored while `cfg_mode_i` is 1. After configuration mode is left, the full window is counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per time-base tick |
| limit_i | input | 8 | Window limit in units of 256 ticks |
| svc_rd_i | input | 1 | Read strobe of the upper register byte (service) |
| cfg_mode_i | input | 1 | Configuration mode active |
| test_dis_i | input | 1 | Test disable bit |
| flag_wr_i | input | 1 | Write strobe to the upper register byte |
| flag_wdata_i | input | 1 | Write data for bit 15 (fault flag) |
| fault_o | output | 1 | Sticky fault flag |
| halt_tt_o | output | 1 | Request to stop time-triggered traffic |
| silent_o | output | 1 | Request for silent mode |

## Verification
A table runs full windows for limits 1, 2, 3 and 5. For each one the bench checks the flag one tick before expiry and again at expiry, which exposes any off-by-one or wrong unit scaling. Limit 0 is run with the disable bit off and on. The bit alone, with a nonzero limit, is also run, which shows whether the disable is an AND or an OR of the two conditions. Directed cases cover these points:
- a service in mid-window
- a service that coincides with a tick
- ticks during configuration mode
- every form of flag write, in and out of configuration mode
- reset while the flag is set

Together they separate a restart from a pause, and a proper clear from a spurious one.

// File: rtl/app_wdog_pkg.sv
package app_wdog_pkg;
  localparam int unsigned LIM_W = 8;
  localparam int unsigned PRE_W = 8;
  localparam int unsigned ELAPSED_W = LIM_W + PRE_W + 1;
  typedef logic [LIM_W-1:0] limit_t;
  typedef logic [PRE_W-1:0] pre_t;
  typedef logic [ELAPSED_W-1:0] elapsed_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i && (cnt_q == MAX);
endmodule

// File: rtl/wdog_window_cnt.sv
module wdog_window_cnt #(
  parameter int unsigned W        = 8,
  parameter bit          SATURATE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  generate
    if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == MAX) ? cnt_q : cnt_q + 1'b1;
    end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_fault_ctl.sv
module wdog_fault_ctl
  import app_wdog_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  limit_t limit_i,
  input  logic   svc_rd_i,
  input  logic   cfg_mode_i,
  input  logic   test_dis_i,
  input  logic   flag_wr_i,
  input  logic   flag_wdata_i,
  input  limit_t unit_cnt_i,
  input  pre_t   pre_cnt_i,
  output logic   step_o,
  output logic   clr_o,
  output logic   fault_o
);
  logic     disabled;
  logic     run;
  logic     expire;
  logic     clear_ok;
  elapsed_t elapsed_nxt;
  elapsed_t window;

  // both conditions needed to switch off
  assign disabled    = test_dis_i && (limit_i == '0);
  assign run         = !cfg_mode_i && !disabled && !fault_o;
  assign elapsed_nxt = {1'b0, unit_cnt_i, pre_cnt_i} + 1'b1;
  assign window      = {1'b0, limit_i, {PRE_W{1'b0}}};
  // service wins over a coincident tick
  assign expire      = run && tick_i && !svc_rd_i && (elapsed_nxt >= window);
  assign step_o      = run && tick_i && !svc_rd_i;
  assign clr_o       = !run || svc_rd_i || expire;
  assign clear_ok    = cfg_mode_i && flag_wr_i && !flag_wdata_i;

  logic fault_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fault_q <= 1'b0;
    else if (expire)   fault_q <= 1'b1;
    else if (clear_ok) fault_q <= 1'b0;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/app_wdog.sv
module app_wdog
  import app_wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             svc_rd_i,
  input  logic             cfg_mode_i,
  input  logic             test_dis_i,
  input  logic             flag_wr_i,
  input  logic             flag_wdata_i,
  output logic             fault_o,
  output logic             halt_tt_o,
  output logic             silent_o
);
  logic   step;
  logic   clr;
  logic   unit_step;
  pre_t   pre_cnt;
  limit_t unit_cnt;
  logic   fault;

  wdog_prescaler #(.W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (step),
    .cnt_o  (pre_cnt),
    .wrap_o (unit_step)
  );

  wdog_window_cnt #(.W(LIM_W), .SATURATE(1'b1)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (unit_step),
    .cnt_o  (unit_cnt)
  );

  wdog_fault_ctl u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .limit_i      (limit_i),
    .svc_rd_i     (svc_rd_i),
    .cfg_mode_i   (cfg_mode_i),
    .test_dis_i   (test_dis_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .unit_cnt_i   (unit_cnt),
    .pre_cnt_i    (pre_cnt),
    .step_o       (step),
    .clr_o        (clr),
    .fault_o      (fault)
  );

  assign fault_o   = fault;
  assign halt_tt_o = fault;
  assign silent_o  = fault;
endmodule

// File: rtl/app_wdog_chk.sv
module app_wdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [7:0] limit_i,
  input logic       svc_rd_i,
  input logic       cfg_mode_i,
  input logic       test_dis_i,
  input logic       flag_wr_i,
  input logic       flag_wdata_i,
  input logic       fault_o,
  input logic       halt_tt_o,
  input logic       silent_o
);
  a_r2_svc_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_rd_i && !fault_o) |=> !fault_o);

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !(cfg_mode_i && flag_wr_i && !flag_wdata_i)) |=> fault_o);

  a_r5_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_tt_o == fault_o) && (silent_o == fault_o));

  a_r6_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(cfg_mode_i && flag_wr_i && !flag_wdata_i));

  a_r7_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && flag_wr_i && (!cfg_mode_i || flag_wdata_i)) |=> fault_o);

  a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_dis_i && limit_i == 8'h00 && !fault_o) |=> !fault_o);

  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i && !fault_o) |=> !fault_o);

  a_r1_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !fault_o) |=> !fault_o);
endmodule

bind app_wdog app_wdog_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .limit_i      (limit_i),
  .svc_rd_i     (svc_rd_i),
  .cfg_mode_i   (cfg_mode_i),
  .test_dis_i   (test_dis_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .fault_o      (fault_o),
  .halt_tt_o    (halt_tt_o),
  .silent_o     (silent_o)
);

// File: tb/app_wdog_tb_top.sv
module app_wdog_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] limit_i = 8'd1;
  logic       svc_rd_i = 1'b0;
  logic       cfg_mode_i = 1'b0;
  logic       test_dis_i = 1'b0;
  logic       flag_wr_i = 1'b0;
  logic       flag_wdata_i = 1'b0;
  logic       fault_o, halt_tt_o, silent_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  app_wdog dut_i (.*);

  // {limit, disable bit, ticks to fault (0 = never)}
  localparam int N_VEC = 7;
  localparam logic [25:0] VEC [N_VEC] = '{
    {8'd1, 1'b0, 17'd256},
    {8'd2, 1'b0, 17'd512},
    {8'd0, 1'b0, 17'd1},
    {8'd3, 1'b0, 17'd768},
    {8'd0, 1'b1, 17'd0},
    {8'd1, 1'b1, 17'd256},
    {8'd5, 1'b0, 17'd1280}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i) tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic service();
    @(negedge clk_i) svc_rd_i = 1'b1;
    @(negedge clk_i) svc_rd_i = 1'b0;
  endtask

  task automatic wr_flag(input logic d);
    @(negedge clk_i) begin flag_wr_i = 1'b1; flag_wdata_i = d; end
    @(negedge clk_i) flag_wr_i = 1'b0;
  endtask

  task automatic cfg_clear();
    @(negedge clk_i) cfg_mode_i = 1'b1;
    wr_flag(1'b0);
    @(negedge clk_i) cfg_mode_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk_i);
    chk(fault_o, 1'b0, "R9 fault in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(fault_o, 1'b0, "R9 fault after reset");
    chk(halt_tt_o | silent_o, 1'b0, "R5 requests after reset");

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk_i) begin
        limit_i = VEC[i][25:18]; test_dis_i = VEC[i][17];
      end
      service();
      if (VEC[i][16:0] == 17'd0) begin
        ticks(2000);
        chk(fault_o, 1'b0, "R8 disabled, no fault");
      end else begin
        ticks(int'(VEC[i][16:0]) - 1);
        chk(fault_o, 1'b0, "R1 one tick before expiry");
        ticks(1);
        chk(fault_o, 1'b1, (VEC[i][25:18] == 8'd0) ? "R3 zero window" : "R1 expiry");
        chk(halt_tt_o && silent_o, 1'b1, "R5 halt and silent");
        cfg_clear();
        chk(fault_o, 1'b0, "R6 clear in config");
      end
    end

    // R2 mid-window service restarts count
    @(negedge clk_i) begin limit_i = 8'd1; test_dis_i = 1'b0; end
    service();
    ticks(200);
    service();
    ticks(255);
    chk(fault_o, 1'b0, "R2 restart after service");
    // R2 tick coincident with service is not counted
    @(negedge clk_i) begin svc_rd_i = 1'b1; tick_i = 1'b1; end
    @(negedge clk_i) begin svc_rd_i = 1'b0; tick_i = 1'b0; end
    ticks(255);
    chk(fault_o, 1'b0, "R2 coincident tick ignored");
    ticks(1);
    chk(fault_o, 1'b1, "R2 expiry after coincident service");

    // R4 sticky through service and ticks
    service();
    ticks(300);
    chk(fault_o, 1'b1, "R4 sticky");
    // R7 write 0 outside config, write 1 in config
    wr_flag(1'b0);
    chk(fault_o, 1'b1, "R7 write outside config");
    @(negedge clk_i) cfg_mode_i = 1'b1;
    wr_flag(1'b1);
    chk(fault_o, 1'b1, "R7 write of one");
    wr_flag(1'b0);
    chk(fault_o, 1'b0, "R6 clear");
    // R10 ticks frozen in config, count restarts at exit
    @(negedge clk_i) cfg_mode_i = 1'b0;
    ticks(100);
    @(negedge clk_i) cfg_mode_i = 1'b1;
    ticks(400);
    chk(fault_o, 1'b0, "R10 no fault in config");
    @(negedge clk_i) cfg_mode_i = 1'b0;
    ticks(255);
    chk(fault_o, 1'b0, "R10 window restarted at exit");
    ticks(1);
    chk(fault_o, 1'b1, "R10 expiry after exit");

    // R9 reset clears fault and counters
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i);
    chk(fault_o, 1'b0, "R9 reset clears fault");
    rst_ni = 1'b1;
    ticks(255);
    chk(fault_o, 1'b0, "R9 counters cleared");
    ticks(1);
    chk(fault_o, 1'b1, "R9 full window after reset");

    done = 1'b1;
    finish_run();
  end
endmodule